// File: doc/BRIEF.md
# I2C slave byte engine

This block is the byte-level engine of a two-wire bus slave. It watches SCL and SDA through a synchronizer. It recognises START, repeated START and STOP, and compares the first byte after a START with a 7-bit own address. After that it receives or sends data bytes, MSB first. A host-side register port answers each event. The port has a response strobe that chooses ACK or NACK, a write strobe that supplies transmit data, a data register holding the last received byte, and status flags for address/stop, data and collision.

The bus is reached through separate input and output wires, so an external tri-state driver can drive the real lines. An output at 1 releases the line and an output at 0 pulls it low. While the host owes an answer, the engine stretches the clock by holding SCL low.

The engine also watches for lost drive. If it sends a high level or a NACK and the line reads low, it gives up both of its drives and returns to idle. A following START is still accepted.

Top module: `i2c_slave_engine`

## Requirements
- R1: After reset both bus outputs are 1 (released) and all flags and status bits are 0.
- R2: A START (SDA falls while SCL high) or repeated START restarts address reception from any state, including mid-byte. A STOP (SDA rises while SCL high) returns the engine to idle and releases both lines.
- R3: The address byte arrives MSB first. Bits 7..1 hold the address and bit 0 is R/W (1 = read). On a match, after the 8th SCL falling edge, flag_as_o is set, stop_o is cleared, rw_o takes bit 0, and SCL is held low.
- R4: On an address mismatch no flag is set, SCL is not held, and SDA stays released during the 9th clock.
- R5: In a wait state, resp_valid_i releases the SCL hold and drives the 9th-clock bit: SDA low when resp_nack_i is 0 (ACK), released when it is 1 (NACK).
- R6: In receive mode, each byte (MSB first) appears on data_rdata_o after its 8th falling edge. At that point flag_data_o is set and SCL is held low until the host responds.
- R7: After the engine NACKs a received byte, further clocks have no effect: no flag, no hold, and SDA released. This lasts until a new START.
- R8: When a read address is ACKed, the falling edge of the 9th clock sets flag_data_o and holds SCL. data_wr_i then loads the byte and releases the hold. Bits are sent MSB first, and SDA only falls while SCL is low. A master ACK (line low on the 9th clock) sets flag_data_o and holds again.
- R9: A master NACK (line high on the 9th clock) sets flag_data_o and mnack_o without a hold. SDA stays released until a new START.
- R10: If the engine outputs 1 (a data bit or a NACK) and SDA reads low at an SCL rising edge, flag_coll_o is set, both lines are released, and the engine goes idle. The next START is accepted.
- R11: A STOP after an address match in the same transfer sets flag_as_o with stop_o = 1 and no hold. A STOP with no match sets no flag.
- R12: While SCL is held, only the write that services the wait clears the flags. Otherwise resp_valid_i or data_wr_i clears flag_as_o, flag_data_o and flag_coll_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| own_addr_i | input | ADDR_W | Own slave address |
| sda_in_i | input | 1 | SDA line level |
| scl_in_i | input | 1 | SCL line level |
| sda_out_o | output | 1 | SDA drive, 0 = pull low, 1 = release |
| scl_out_o | output | 1 | SCL drive, 0 = hold low, 1 = release |
| resp_valid_i | input | 1 | Host response strobe (ACK/NACK choice) |
| resp_nack_i | input | 1 | 1 = NACK, 0 = ACK, with resp_valid_i |
| data_wr_i | input | 1 | Host write of transmit data |
| data_wdata_i | input | DATA_W | Transmit byte |
| data_rdata_o | output | DATA_W | Last received byte |
| flag_as_o | output | 1 | Address match or STOP flag |
| stop_o | output | 1 | 1 = flag_as_o came from a STOP |
| flag_data_o | output | 1 | Data byte flag |
| flag_coll_o | output | 1 | Collision flag |
| rw_o | output | 1 | R/W bit of the matched address |
| mnack_o | output | 1 | Master answered the last sent byte with NACK |

## Verification
The bench builds the engine with ADDR_W = 7, DATA_W = 8 and SYNC_STAGES = 2. The 7-bit address space is small, so every one of the 128 addresses is offered in turn. Each offer checks match or mismatch, hold, ACK level, and the STOP flag that follows. The bench's 6-cycle SCL half-period exceeds the two-flop plus edge-detect latency, so clock stretching, collisions and both ACK outcomes are exercised at the real bit edges. Sixteen arithmetic byte patterns are sent in each direction.

// File: rtl/i2c_se_pkg.sv
package i2c_se_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AWAIT, S_ACK, S_RX, S_RWAIT, S_TWAIT, S_TX, S_TACK
  } st_e;
endpackage

// File: rtl/i2c_se_sync.sv
module i2c_se_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) r_q <= '1;
    else         r_q <= {r_q[STAGES-2:0], d_i};
  end

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/i2c_se_linemon.sv
module i2c_se_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sda_i,
  input  logic scl_i,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int LINES = 2;  // bit 0 sda, bit 1 scl

  logic [LINES-1:0] raw, syn, prev_q;
  logic scl_hi;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_sync
    i2c_se_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw[g]),
      .q_o   (syn[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= syn;
  end

  assign scl_hi  = syn[1] & prev_q[1];
  assign start_o = scl_hi & prev_q[0] & ~syn[0];
  assign stop_o  = scl_hi & ~prev_q[0] & syn[0];
  assign rise_o  = syn[1] & ~prev_q[1];
  assign fall_o  = ~syn[1] & prev_q[1];
  assign sda_o   = syn[0];
endmodule

// File: rtl/i2c_se_shifter.sv
module i2c_se_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= load_val_i;
    else if (shift_i) q_o <= {q_o[W-2:0], bit_i};
  end
endmodule

// File: rtl/i2c_slave_engine.sv
module i2c_slave_engine
  import i2c_se_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] own_addr_i,
  input  logic              sda_in_i,
  input  logic              scl_in_i,
  output logic              sda_out_o,
  output logic              scl_out_o,
  input  logic              resp_valid_i,
  input  logic              resp_nack_i,
  input  logic              data_wr_i,
  input  logic [DATA_W-1:0] data_wdata_i,
  output logic [DATA_W-1:0] data_rdata_o,
  output logic              flag_as_o,
  output logic              stop_o,
  output logic              flag_data_o,
  output logic              flag_coll_o,
  output logic              rw_o,
  output logic              mnack_o
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W);

  st_e st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, rdata_q;
  logic sda_q, hold_q, nack_q, rw_q, sel_q;
  logic flag_as_q, stop_q, flag_data_q, flag_coll_q, mnack_q;
  logic sda_s, start_w, stop_w, rise_w, fall_w;
  logic sh_load, sh_shift, service, clr, match;

  i2c_se_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sda_i  (sda_in_i),
    .scl_i  (scl_in_i),
    .sda_o  (sda_s),
    .start_o(start_w),
    .stop_o (stop_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  assign sh_load  = (st_q == S_TWAIT) && data_wr_i && !start_w && !stop_w;
  assign sh_shift = (((st_q == S_ADDR) || (st_q == S_RX)) && rise_w) ||
                    ((st_q == S_TX) && fall_w && (cnt_q != LAST));

  i2c_se_shifter #(.W(DATA_W)) u_sh (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (sh_load),
    .load_val_i(data_wdata_i),
    .shift_i   (sh_shift),
    .bit_i     (sda_s),
    .q_o       (sh_q)
  );

  assign match   = (sh_q[DATA_W-1 -: ADDR_W] == own_addr_i);
  // only the servicing write may clear flags while the clock is stretched
  assign service = (((st_q == S_AWAIT) || (st_q == S_RWAIT)) && resp_valid_i) ||
                   ((st_q == S_TWAIT) && data_wr_i);
  assign clr     = hold_q ? service : (resp_valid_i | data_wr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= S_IDLE;
      cnt_q       <= '0;
      sda_q       <= 1'b1;
      hold_q      <= 1'b0;
      nack_q      <= 1'b0;
      rw_q        <= 1'b0;
      sel_q       <= 1'b0;
      flag_as_q   <= 1'b0;
      stop_q      <= 1'b0;
      flag_data_q <= 1'b0;
      flag_coll_q <= 1'b0;
      mnack_q     <= 1'b0;
      rdata_q     <= '0;
    end else begin
      if (clr) begin
        flag_as_q   <= 1'b0;
        flag_data_q <= 1'b0;
        flag_coll_q <= 1'b0;
      end
      if (start_w) begin
        st_q    <= S_ADDR;
        cnt_q   <= '0;
        sda_q   <= 1'b1;
        hold_q  <= 1'b0;
        sel_q   <= 1'b0;
        mnack_q <= 1'b0;
      end else if (stop_w) begin
        st_q   <= S_IDLE;
        sda_q  <= 1'b1;
        hold_q <= 1'b0;
        sel_q  <= 1'b0;
        if (sel_q) begin
          flag_as_q <= 1'b1;
          stop_q    <= 1'b1;
        end
      end else begin
        unique case (st_q)
          S_ADDR: begin
            if (rise_w) cnt_q <= cnt_q + 1'b1;
            else if (fall_w && cnt_q == LAST) begin
              if (match) begin
                flag_as_q <= 1'b1;
                stop_q    <= 1'b0;
                rw_q      <= sh_q[0];
                sel_q     <= 1'b1;
                hold_q    <= 1'b1;
                st_q      <= S_AWAIT;
              end else begin
                st_q <= S_IDLE;
              end
            end
          end
          S_AWAIT, S_RWAIT: begin
            if (resp_valid_i) begin
              nack_q <= resp_nack_i;
              sda_q  <= resp_nack_i;
              hold_q <= 1'b0;
              st_q   <= S_ACK;
            end
          end
          S_ACK: begin
            if (rise_w && nack_q && !sda_s) begin
              flag_coll_q <= 1'b1;
              sda_q       <= 1'b1;
              hold_q      <= 1'b0;
              st_q        <= S_IDLE;
            end else if (fall_w) begin
              sda_q <= 1'b1;
              cnt_q <= '0;
              if (nack_q) st_q <= S_IDLE;
              else if (rw_q) begin
                flag_data_q <= 1'b1;
                hold_q      <= 1'b1;
                st_q        <= S_TWAIT;
              end else st_q <= S_RX;
            end
          end
          S_RX: begin
            if (rise_w) cnt_q <= cnt_q + 1'b1;
            else if (fall_w && cnt_q == LAST) begin
              rdata_q     <= sh_q;
              flag_data_q <= 1'b1;
              hold_q      <= 1'b1;
              st_q        <= S_RWAIT;
            end
          end
          S_TWAIT: begin
            if (data_wr_i) begin
              sda_q  <= data_wdata_i[DATA_W-1];
              hold_q <= 1'b0;
              cnt_q  <= '0;
              st_q   <= S_TX;
            end
          end
          S_TX: begin
            if (rise_w) begin
              if (sda_q && !sda_s) begin
                flag_coll_q <= 1'b1;
                sda_q       <= 1'b1;
                hold_q      <= 1'b0;
                st_q        <= S_IDLE;
              end else cnt_q <= cnt_q + 1'b1;
            end else if (fall_w) begin
              if (cnt_q == LAST) begin
                sda_q <= 1'b1;
                st_q  <= S_TACK;
              end else sda_q <= sh_q[DATA_W-2];
            end
          end
          S_TACK: begin
            if (rise_w) mnack_q <= sda_s;
            else if (fall_w) begin
              flag_data_q <= 1'b1;
              if (mnack_q) st_q <= S_IDLE;
              else begin
                hold_q <= 1'b1;
                st_q   <= S_TWAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_out_o    = sda_q;
  assign scl_out_o    = ~hold_q;
  assign data_rdata_o = rdata_q;
  assign flag_as_o    = flag_as_q;
  assign stop_o       = stop_q;
  assign flag_data_o  = flag_data_q;
  assign flag_coll_o  = flag_coll_q;
  assign rw_o         = rw_q;
  assign mnack_o      = mnack_q;
endmodule

// File: rtl/i2c_slave_engine_chk.sv
module i2c_slave_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_in_i,
  input logic sda_out_o,
  input logic scl_out_o,
  input logic flag_as_o,
  input logic stop_o,
  input logic flag_data_o,
  input logic flag_coll_o,
  input logic mnack_o
);
  // R10
  coll_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_coll_o) |-> (sda_out_o && scl_out_o));

  // R8
  sda_fall_scl_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_out_o) |-> !$past(scl_in_i));

  // R12
  hold_has_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !scl_out_o |-> (flag_as_o || flag_data_o));

  // R3
  match_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_as_o) && !stop_o) |-> !scl_out_o);

  // R11
  stop_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_as_o) && stop_o) |-> scl_out_o);

  // R9
  mnack_no_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_data_o) && mnack_o) |-> scl_out_o);

  // R6
  data_holds_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(flag_data_o) && !mnack_o) |-> !scl_out_o);
endmodule

bind i2c_slave_engine i2c_slave_engine_chk u_chk (.*);

// File: tb/i2c_slave_engine_test.sv
module i2c_slave_engine_test;
  localparam int Q = 6;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_sda = 1'b1, m_scl = 1'b1;
  logic resp_valid = 1'b0, resp_nack = 1'b0, data_wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic sda_out, scl_out, flag_as, stop_f, flag_data, flag_coll, rw, mnack;
  logic sda_line, scl_line;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  assign sda_line = m_sda & sda_out;
  assign scl_line = m_scl & scl_out;

  i2c_slave_engine uut (
    .clk_i(clk), .rst_ni(rst_ni), .own_addr_i(OWN),
    .sda_in_i(sda_line), .scl_in_i(scl_line),
    .sda_out_o(sda_out), .scl_out_o(scl_out),
    .resp_valid_i(resp_valid), .resp_nack_i(resp_nack),
    .data_wr_i(data_wr), .data_wdata_i(wdata), .data_rdata_o(rdata),
    .flag_as_o(flag_as), .stop_o(stop_f), .flag_data_o(flag_data),
    .flag_coll_o(flag_coll), .rw_o(rw), .mnack_o(mnack)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_scl_hi();
    int k = 0;
    while (!scl_line && k < 400) begin tick(1); k++; end
    if (k >= 400) chk("R5 clock hold never released", 0, 1);
  endtask

  task automatic m_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; wait_scl_hi(); tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; wait_scl_hi(); tick(Q);
    m_sda = 1'b1; tick(Q);
  endtask

  task automatic m_bit_w(input logic b);
    m_sda = b; tick(Q);
    m_scl = 1'b1; wait_scl_hi(); tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_bit_r(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; wait_scl_hi(); tick(Q/2);
    b = sda_line; tick(Q - Q/2);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic m_byte_w(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
  endtask

  task automatic m_byte_r(output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin m_bit_r(b); v[i] = b; end
  endtask

  task automatic host_resp(input logic nack);
    resp_valid = 1'b1; resp_nack = nack; tick(1);
    resp_valid = 1'b0; resp_nack = 1'b0; tick(1);
  endtask

  task automatic host_wr(input logic [7:0] v);
    data_wr = 1'b1; wdata = v; tick(1);
    data_wr = 1'b0; tick(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic b;
    logic [7:0] v, got;
    tick(3); rst_ni = 1'b1; tick(2);
    // R1 reset state
    chk("R1 sda_out", sda_out, 1); chk("R1 scl_out", scl_out, 1);
    chk("R1 flags", {flag_as, flag_data, flag_coll, stop_f, rw, mnack}, 0);

    // R3 R4 R5 R11 full address sweep, write direction
    for (int a = 0; a < 128; a++) begin
      m_start();
      m_byte_w({a[6:0], 1'b0});
      if (a[6:0] == OWN) begin
        chk("R3 match flag", flag_as, 1); chk("R3 stop qual", stop_f, 0);
        chk("R3 rw", rw, 0); chk("R3 hold", scl_out, 0);
        host_resp(1'b0);
        chk("R5 hold release", scl_out, 1); chk("R12 cleared", flag_as, 0);
        m_bit_r(b); chk("R5 ack level", b, 0);
        m_stop();
        chk("R11 stop flag", flag_as, 1); chk("R11 stop qual", stop_f, 1);
        chk("R11 no hold", scl_out, 1);
        host_resp(1'b0); chk("R12 clear idle", flag_as, 0);
      end else begin
        chk("R4 no flag", flag_as, 0); chk("R4 no hold", scl_out, 1);
        m_bit_r(b); chk("R4 no ack", b, 1);
        m_stop(); chk("R11 unaddressed stop", flag_as, 0);
      end
    end

    // R6 receive patterns, then R5 nack and R7 ignore
    m_start(); m_byte_w({OWN, 1'b0}); host_resp(1'b0); m_bit_r(b);
    for (int k = 0; k < 16; k++) begin
      v = 8'((k * 37 + 11) % 256);
      m_byte_w(v);
      chk("R6 data flag", flag_data, 1); chk("R6 rdata", rdata, v);
      chk("R6 hold", scl_out, 0);
      host_resp(k == 15);
      m_bit_r(b); chk("R5 ack/nack level", b, (k == 15) ? 1 : 0);
    end
    m_byte_w(8'hA5);
    chk("R7 no flag", flag_data, 0); chk("R7 no hold", scl_out, 1);
    m_bit_r(b); chk("R7 no ack", b, 1);
    chk("R7 rdata kept", rdata, 8'((15 * 37 + 11) % 256));
    m_stop(); host_resp(1'b0);

    // R8 transmit patterns, R9 master nack
    m_start(); m_byte_w({OWN, 1'b1});
    chk("R3 rw read", rw, 1);
    host_resp(1'b0); m_bit_r(b); chk("R5 read ack", b, 0);
    chk("R8 first request", flag_data, 1); chk("R8 first hold", scl_out, 0);
    for (int k = 0; k < 16; k++) begin
      v = 8'((k * 53 + 7) % 256);
      host_wr(v);
      chk("R8 hold released", scl_out, 1);
      m_byte_r(got); chk("R8 tx byte", got, v);
      if (k < 15) begin
        m_bit_w(1'b0);
        chk("R8 next request", flag_data, 1); chk("R8 hold", scl_out, 0);
        chk("R8 mnack", mnack, 0);
      end else begin
        m_bit_w(1'b1);
        chk("R9 flag", flag_data, 1); chk("R9 mnack", mnack, 1);
        chk("R9 no hold", scl_out, 1); chk("R9 sda released", sda_out, 1);
      end
    end
    m_byte_r(got); chk("R9 released after nack", got, 8'hFF);
    m_stop(); host_resp(1'b0);

    // R10 collision on a transmitted 1, then restart accepted (R2)
    m_start(); m_byte_w({OWN, 1'b1}); host_resp(1'b0); m_bit_r(b);
    host_wr(8'hFF);
    m_bit_w(1'b0);
    chk("R10 coll flag", flag_coll, 1); chk("R10 sda released", sda_out, 1);
    chk("R10 scl released", scl_out, 1);
    m_start(); m_byte_w({OWN, 1'b0});
    chk("R10 start after coll", flag_as, 1);
    host_resp(1'b0); m_bit_r(b); m_stop(); host_resp(1'b0);
    chk("R12 coll cleared", flag_coll, 0);

    // R10 collision on a NACK
    m_start(); m_byte_w({OWN, 1'b0}); host_resp(1'b0); m_bit_r(b);
    m_byte_w(8'h3C); host_resp(1'b1);
    m_bit_w(1'b0);
    chk("R10 nack coll", flag_coll, 1); chk("R10 nack sda", sda_out, 1);
    m_stop(); host_resp(1'b0);

    // R2 repeated START mid-byte
    m_start(); m_byte_w({OWN, 1'b0}); host_resp(1'b0); m_bit_r(b);
    m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1);
    m_start(); m_byte_w({OWN, 1'b0});
    chk("R2 restart match", flag_as, 1); chk("R2 restart qual", stop_f, 0);
    host_resp(1'b1); m_bit_r(b); chk("R5 address nack", b, 1);
    m_stop(); host_resp(1'b0);

    // R2 STOP mid-byte
    m_start(); m_byte_w({OWN, 1'b0}); host_resp(1'b0); m_bit_r(b);
    m_bit_w(1'b0); m_bit_w(1'b1);
    m_stop();
    chk("R2 stop mid byte", flag_as, 1); chk("R2 stop qual", stop_f, 1);
    chk("R2 lines released", {sda_out, scl_out}, 3);
    host_resp(1'b0);

    // R12 non-servicing write keeps flag and hold
    m_start(); m_byte_w({OWN, 1'b0});
    host_wr(8'h11);
    chk("R12 flag kept", flag_as, 1); chk("R12 hold kept", scl_out, 0);
    host_resp(1'b0); chk("R12 serviced", flag_as, 0);
    m_bit_r(b); m_stop(); host_resp(1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule